// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block delivers inter-processor software interrupts among up to eight processors, each of which can hold up to sixteen software interrupt numbers. A processor raises such an interrupt by presenting a 32-bit trigger word for one cycle together with its own processor number. The word names the interrupt number and says which processors receive it. For every receiving processor the block keeps a bitmap of the processors that asked for the interrupt, plus a pending flag.

When a receiving processor takes an interrupt, the block reports the interrupt number with the lowest-numbered requester folded into the upper bits of the reply. It then retires only that one requester. The pending flag stays up until every requester has been served. The same bitmaps can be set or cleared a byte at a time, and they can be read back through a combinational port. Choosing among interrupts of different priority belongs to a neighbouring block.

Top module: `sgi_dispatch`

## Requirements
- R1: After synchronous reset every source bitmap reads zero, every pending bit is clear, and `ack_done` and `ack_err` are low.
- R2: The interrupt number is taken from trigger word bits [9:0]. A trigger whose number is 16 or more (not below NUM_SGI) changes no state. Bits outside [25:24], [23:16] and [9:0] do not affect the result.
- R3: Filter code 0 in trigger bits [25:24] sends the interrupt to the processors whose bits are set in the list field [23:16], where bit 16+n selects processor n.
- R4: Filter code 1 targets every processor except the requester. Code 2 targets only the requester. Code 3 targets every processor.
- R5: For each targeted processor, the trigger sets the requester's bit in that processor's bitmap for the interrupt and sets the pending bit. Both are visible in the cycle after the strobe. Pending bit index is cpu*NUM_SGI + sgi.
- R6: An acknowledge of a non-empty bitmap raises `ack_done` one cycle later. `ack_word` then equals sgi | (src[2:0] << 10), where src is the lowest set bit of the bitmap, and that bit is cleared.
- R7: An acknowledge that leaves other requesters in the bitmap keeps the pending bit set. The bit clears only when the bitmap becomes empty.
- R8: A clearing byte write removes the written bits from the bitmap, and clears the pending bit if the bitmap becomes zero.
- R9: A setting byte write ORs the written bits into the bitmap and sets the pending bit, even when the data is zero.
- R10: An acknowledge of an empty bitmap raises `ack_err` one cycle later, leaves `ack_done` low and changes no bitmap or pending bit.
- R11: When an acknowledge and a trigger hit the same entry in one cycle, the acknowledge clear happens first and the trigger set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_valid | input | 1 | One-cycle trigger strobe |
| trig_cpu | input | 3 | Requesting processor |
| trig_word | input | 32 | Trigger word (number, filter, list) |
| ack_valid | input | 1 | Acknowledge request |
| ack_cpu | input | 3 | Acknowledging processor |
| ack_sgi | input | 4 | Interrupt number acknowledged |
| ack_done | output | 1 | Acknowledge served, one cycle later |
| ack_err | output | 1 | Acknowledge hit an empty bitmap |
| ack_word | output | 13 | Number with source in bits [12:10] |
| map_wr_valid | input | 1 | Byte write strobe to a bitmap |
| map_wr_set | input | 1 | 1 = set bits, 0 = clear bits |
| map_cpu | input | 3 | Target processor of the byte write |
| map_sgi | input | 4 | Interrupt number of the byte write |
| map_wr_data | input | 8 | Source bits to set or clear |
| rd_cpu | input | 3 | Processor for bitmap read |
| rd_sgi | input | 4 | Interrupt number for bitmap read |
| rd_map | output | 8 | Bitmap selected by rd_cpu/rd_sgi |
| pend_vec | output | 128 | Pending bits, index cpu*16+sgi |

## Verification
The bench uses five trigger patterns:
- an explicit list, which shows the list decode;
- the three broadcast filters, whose pending sets differ only in whether the requester is included;
- an out-of-range number, which separates the ignored case from a real target;
- a word with stray upper bits;
- three requesters on one entry.

The three-requester case shows the lowest-first ordering and that pending survives partial retirement. Byte writes and an acknowledge of an empty or zero-set entry distinguish the set path, the clear path and the error path. A same-cycle acknowledge and trigger from the same requester shows whether the clear is applied before the set.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int TRIG_ID_W   = 10;
    localparam int TRIG_LIST_L = 16;
    localparam int TRIG_FILT_L = 24;
    localparam int SRC_SHIFT   = 10;
    localparam int SRC_FIELD_W = 3;
    localparam int RSP_W       = SRC_SHIFT + SRC_FIELD_W;

    typedef enum logic [1:0] {
        FILT_LIST   = 2'd0,
        FILT_OTHERS = 2'd1,
        FILT_SELF   = 2'd2,
        FILT_ALL    = 2'd3
    } filt_e;

    typedef struct packed {
        filt_e                 filt;
        logic [7:0]            list;
        logic [TRIG_ID_W-1:0]  id;
    } trig_fields_t;

    typedef struct packed {
        logic       found;
        logic [2:0] idx;
    } pick_t;

    function automatic trig_fields_t unpack_trig(input logic [31:0] w);
        trig_fields_t f;
        f.filt = filt_e'(w[TRIG_FILT_L +: 2]);
        f.list = w[TRIG_LIST_L +: 8];
        f.id   = w[TRIG_ID_W-1:0];
        return f;
    endfunction

    function automatic pick_t lowest_set(input logic [7:0] v);
        pick_t r;
        r = '0;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) begin
                r.found = 1'b1;
                r.idx   = 3'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/sgi_trig_decode.sv
module sgi_trig_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W = $clog2(NUM_CPU),
    localparam int SGI_W = $clog2(NUM_SGI)
) (
    input  logic               trig_valid,
    input  logic [CPU_W-1:0]   trig_cpu,
    input  logic [31:0]        trig_word,
    output logic               tgt_fire,
    output logic [SGI_W-1:0]   tgt_sgi,
    output logic [NUM_CPU-1:0] tgt_mask
);
    trig_fields_t       f;
    logic [NUM_CPU-1:0] self_bit;

    always_comb begin
        f        = unpack_trig(trig_word);
        self_bit = '0;
        self_bit[trig_cpu] = 1'b1;
        unique case (f.filt)
            FILT_LIST:   tgt_mask = f.list[NUM_CPU-1:0];
            FILT_OTHERS: tgt_mask = ~self_bit;
            FILT_SELF:   tgt_mask = self_bit;
            default:     tgt_mask = '1;
        endcase
        tgt_sgi  = f.id[SGI_W-1:0];
        tgt_fire = trig_valid && (f.id < TRIG_ID_W'(NUM_SGI));
    end
endmodule

// File: rtl/sgi_cell.sv
module sgi_cell #(
    parameter int NUM_CPU = 8,
    localparam int CPU_W = $clog2(NUM_CPU)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_hit,
    input  logic [NUM_CPU-1:0] clr_bit,
    input  logic               wr_hit,
    input  logic               wr_set,
    input  logic [NUM_CPU-1:0] wr_data,
    input  logic               trig_hit,
    input  logic [CPU_W-1:0]   trig_src,
    output logic [NUM_CPU-1:0] src_map,
    output logic               pend
);
    logic [NUM_CPU-1:0] map_nx;
    logic               pend_nx;

    // order inside a cycle: acknowledge clear, byte write, trigger set
    always_comb begin
        map_nx  = src_map;
        pend_nx = pend;
        if (ack_hit) begin
            map_nx = map_nx & ~clr_bit;
            if (map_nx == '0) pend_nx = 1'b0;
        end
        if (wr_hit) begin
            if (wr_set) begin
                map_nx  = map_nx | wr_data;
                pend_nx = 1'b1;
            end else begin
                map_nx = map_nx & ~wr_data;
                if (map_nx == '0) pend_nx = 1'b0;
            end
        end
        if (trig_hit) begin
            map_nx[trig_src] = 1'b1;
            pend_nx          = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_map <= '0;
            pend    <= 1'b0;
        end else begin
            src_map <= map_nx;
            pend    <= pend_nx;
        end
    end

    AST_TRIG_MARKS: assert property (@(posedge clk) disable iff (rst)
        trig_hit |=> (pend && src_map[$past(trig_src)])); // R5

    AST_PEND_DROP_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> (src_map == '0)); // R7

    AST_ACK_RETIRES_ONE: assert property (@(posedge clk) disable iff (rst)
        (ack_hit && !wr_hit && !trig_hit) |=>
            ($countones(src_map) + 1 == $countones($past(src_map)))); // R6
endmodule

// File: rtl/sgi_ack_unit.sv
module sgi_ack_unit
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int SGI_W = $clog2(NUM_SGI)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ack_valid,
    input  logic [SGI_W-1:0]   ack_sgi,
    input  logic [NUM_CPU-1:0] sel_map,
    output logic               ack_take,
    output logic [NUM_CPU-1:0] clr_bit,
    output logic               ack_done,
    output logic               ack_err,
    output logic [RSP_W-1:0]   ack_word
);
    pick_t            pick;
    logic [RSP_W-1:0] rsp_nx;

    always_comb begin
        pick     = lowest_set(8'(sel_map));
        ack_take = ack_valid && pick.found;
        clr_bit  = '0;
        clr_bit[pick.idx] = pick.found;
        rsp_nx   = '0;
        rsp_nx[SGI_W-1:0] = ack_sgi;
        rsp_nx[SRC_SHIFT +: SRC_FIELD_W] = pick.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_done <= 1'b0;
            ack_err  <= 1'b0;
            ack_word <= '0;
        end else begin
            ack_done <= ack_take;
            ack_err  <= ack_valid && !pick.found;
            if (ack_take) ack_word <= rsp_nx;
        end
    end

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
        ack_done |-> $past(ack_valid)); // R6

    AST_ERR_ON_EMPTY: assert property (@(posedge clk) disable iff (rst)
        ack_err |-> ($past(ack_valid) && $past(sel_map) == '0)); // R10
endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 8,
    parameter int NUM_SGI = 16,
    localparam int CPU_W = $clog2(NUM_CPU),
    localparam int SGI_W = $clog2(NUM_SGI)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       trig_valid,
    input  logic [CPU_W-1:0]           trig_cpu,
    input  logic [31:0]                trig_word,
    input  logic                       ack_valid,
    input  logic [CPU_W-1:0]           ack_cpu,
    input  logic [SGI_W-1:0]           ack_sgi,
    output logic                       ack_done,
    output logic                       ack_err,
    output logic [RSP_W-1:0]           ack_word,
    input  logic                       map_wr_valid,
    input  logic                       map_wr_set,
    input  logic [CPU_W-1:0]           map_cpu,
    input  logic [SGI_W-1:0]           map_sgi,
    input  logic [NUM_CPU-1:0]         map_wr_data,
    input  logic [CPU_W-1:0]           rd_cpu,
    input  logic [SGI_W-1:0]           rd_sgi,
    output logic [NUM_CPU-1:0]         rd_map,
    output logic [NUM_CPU*NUM_SGI-1:0] pend_vec
);
    logic               tgt_fire;
    logic [SGI_W-1:0]   tgt_sgi;
    logic [NUM_CPU-1:0] tgt_mask;
    logic               ack_take;
    logic [NUM_CPU-1:0] clr_bit;
    logic [NUM_CPU-1:0] sel_map;
    logic [NUM_CPU-1:0] map_a [NUM_CPU][NUM_SGI];

    sgi_trig_decode #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_dec (
        .trig_valid (trig_valid),
        .trig_cpu   (trig_cpu),
        .trig_word  (trig_word),
        .tgt_fire   (tgt_fire),
        .tgt_sgi    (tgt_sgi),
        .tgt_mask   (tgt_mask)
    );

    assign sel_map = map_a[ack_cpu][ack_sgi];
    assign rd_map  = map_a[rd_cpu][rd_sgi];

    sgi_ack_unit #(.NUM_CPU(NUM_CPU), .NUM_SGI(NUM_SGI)) u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_valid (ack_valid),
        .ack_sgi   (ack_sgi),
        .sel_map   (sel_map),
        .ack_take  (ack_take),
        .clr_bit   (clr_bit),
        .ack_done  (ack_done),
        .ack_err   (ack_err),
        .ack_word  (ack_word)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        for (genvar s = 0; s < NUM_SGI; s++) begin : g_sgi
            logic a_hit, w_hit, t_hit;
            assign a_hit = ack_take && ack_cpu == CPU_W'(c) && ack_sgi == SGI_W'(s);
            assign w_hit = map_wr_valid && map_cpu == CPU_W'(c) && map_sgi == SGI_W'(s);
            assign t_hit = tgt_fire && tgt_mask[c] && tgt_sgi == SGI_W'(s);
            sgi_cell #(.NUM_CPU(NUM_CPU)) u_cell (
                .clk      (clk),
                .rst      (rst),
                .ack_hit  (a_hit),
                .clr_bit  (clr_bit),
                .wr_hit   (w_hit),
                .wr_set   (map_wr_set),
                .wr_data  (map_wr_data),
                .trig_hit (t_hit),
                .trig_src (trig_cpu),
                .src_map  (map_a[c][s]),
                .pend     (pend_vec[c*NUM_SGI+s])
            );
        end
    end
endmodule

// File: tb/sgi_dispatch_bench.sv
`timescale 1ns/1ps
module sgi_dispatch_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig_valid = 1'b0;
    logic [2:0]   trig_cpu = '0;
    logic [31:0]  trig_word = '0;
    logic         ack_valid = 1'b0;
    logic [2:0]   ack_cpu = '0;
    logic [3:0]   ack_sgi = '0;
    logic         ack_done, ack_err;
    logic [12:0]  ack_word;
    logic         map_wr_valid = 1'b0;
    logic         map_wr_set = 1'b0;
    logic [2:0]   map_cpu = '0;
    logic [3:0]   map_sgi = '0;
    logic [7:0]   map_wr_data = '0;
    logic [2:0]   rd_cpu = '0;
    logic [3:0]   rd_sgi = '0;
    logic [7:0]   rd_map;
    logic [127:0] pend_vec;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sgi_dispatch u_sgi_dispatch (.*);

    function automatic logic [127:0] pbit(input int c, input int s);
        return 128'(1) << (c*16 + s);
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic readmap(input int c, input int s, output logic [7:0] m);
        rd_cpu = 3'(c);
        rd_sgi = 4'(s);
        #1;
        m = rd_map;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic trig(input int req, input logic [31:0] w);
        @(negedge clk);
        trig_valid = 1'b1; trig_cpu = 3'(req); trig_word = w;
        @(negedge clk);
        trig_valid = 1'b0;
    endtask

    task automatic ack(input int c, input int s);
        @(negedge clk);
        ack_valid = 1'b1; ack_cpu = 3'(c); ack_sgi = 4'(s);
        @(negedge clk);
        ack_valid = 1'b0;
    endtask

    task automatic bwr(input bit set, input int c, input int s, input logic [7:0] d);
        @(negedge clk);
        map_wr_valid = 1'b1; map_wr_set = set; map_cpu = 3'(c); map_sgi = 4'(s); map_wr_data = d;
        @(negedge clk);
        map_wr_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] m;
        do_reset();
        chk("R1 pend", pend_vec, '0);
        chk("R1 done", ack_done, 0);
        chk("R1 err", ack_err, 0);
        readmap(7, 15, m);
        chk("R1 map", m, 0);
    endtask

    task automatic t_list();
        logic [7:0] m;
        do_reset();
        trig(1, 32'h0025_0003);
        chk("R3 list pend", pend_vec, pbit(0,3) | pbit(2,3) | pbit(5,3));
        readmap(2, 3, m);
        chk("R5 source bit", m, 8'h02);
        ack(0, 3);
        chk("R6 done", ack_done, 1);
        chk("R6 word", ack_word, 13'h403);
        chk("R7 pend dropped", pend_vec, pbit(2,3) | pbit(5,3));
    endtask

    task automatic t_filters();
        logic [127:0] e;
        logic [7:0] m;
        do_reset();
        trig(4, 32'h0100_0007);
        trig(6, 32'h0200_0009);
        trig(0, 32'h0300_0001);
        e = '0;
        for (int c = 0; c < 8; c++) begin
            if (c != 4) e |= pbit(c, 7);
            e |= pbit(c, 1);
        end
        e |= pbit(6, 9);
        chk("R4 filters pend", pend_vec, e);
        readmap(0, 7, m);
        chk("R4 others map", m, 8'h10);
        readmap(6, 9, m);
        chk("R4 self map", m, 8'h40);
        readmap(3, 1, m);
        chk("R4 all map", m, 8'h01);
    endtask

    task automatic t_id();
        do_reset();
        trig(2, 32'h0200_0014);
        chk("R2 out of range ignored", pend_vec, '0);
        trig(3, 32'h3200_0005);
        chk("R2 stray bits", pend_vec, pbit(3,5));
    endtask

    task automatic t_multi();
        logic [7:0] m;
        do_reset();
        trig(5, 32'h0008_0002);
        trig(1, 32'h0008_0002);
        trig(6, 32'h0008_0002);
        readmap(3, 2, m);
        chk("R5 multi map", m, 8'h62);
        ack(3, 2);
        chk("R6 lowest src1", ack_word, 13'h0402);
        chk("R7 still pend", pend_vec, pbit(3,2));
        ack(3, 2);
        chk("R6 src5", ack_word, 13'h1402);
        ack(3, 2);
        chk("R6 src6", ack_word, 13'h1802);
        chk("R7 pend clear", pend_vec, '0);
        ack(3, 2);
        chk("R10 err", ack_err, 1);
        chk("R10 no done", ack_done, 0);
        readmap(3, 2, m);
        chk("R10 map unchanged", m, 0);
    endtask

    task automatic t_bytes();
        logic [7:0] m;
        do_reset();
        bwr(1, 1, 4, 8'h81);
        readmap(1, 4, m);
        chk("R9 set map", m, 8'h81);
        chk("R9 set pend", pend_vec, pbit(1,4));
        bwr(0, 1, 4, 8'h01);
        readmap(1, 4, m);
        chk("R8 partial clear map", m, 8'h80);
        chk("R8 partial clear pend", pend_vec, pbit(1,4));
        bwr(0, 1, 4, 8'h80);
        chk("R8 full clear pend", pend_vec, '0);
        bwr(1, 1, 4, 8'h00);
        chk("R9 zero set pend", pend_vec, pbit(1,4));
        ack(1, 4);
        chk("R10 err zero map", ack_err, 1);
        chk("R10 pend kept", pend_vec, pbit(1,4));
    endtask

    task automatic t_collide();
        logic [7:0] m;
        do_reset();
        trig(2, 32'h0200_000B);
        @(negedge clk);
        ack_valid = 1'b1; ack_cpu = 3'd2; ack_sgi = 4'd11;
        trig_valid = 1'b1; trig_cpu = 3'd2; trig_word = 32'h0200_000B;
        @(negedge clk);
        ack_valid = 1'b0; trig_valid = 1'b0;
        chk("R11 word", ack_word, 13'h080B);
        readmap(2, 11, m);
        chk("R11 map", m, 8'h04);
        chk("R11 pend", pend_vec, pbit(2,11));
    endtask

    initial begin
        t_reset();
        t_list();
        t_filters();
        t_id();
        t_multi();
        t_bytes();
        t_collide();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule